// File: doc/BRIEF.md
# Lockable Round-Robin Victim Selector

This block picks the way to replace when a set-associative cache allocates a new line. The cache has a number of sets, each holding a fixed number of ways. For every set the block keeps two small counters: how many ways are locked, and a round-robin pointer. Locked ways always sit at the bottom of the set, at indices 0 up to the lock count minus one. A victim is therefore always taken from the unlocked ways above them. Because each set can lock a different number of ways, the rotation length differs from set to set.

A single request port carries a set index, an allocate strobe and a two-bit command. The command can lock one more way in the addressed set or release all locks in that set. The chosen victim way, a valid strobe and a rejection flag appear one clock after the request. Tag storage, data storage and miss handling live elsewhere.

Top module: `victim_sel`

## Requirements
- R1: After synchronous reset, every set has zero locked ways and a pointer at way 0, and `victim_valid` and `lock_err` are low.
- R2: An accepted allocate drives `victim_valid` high for exactly one cycle, on the cycle after the request, with `victim_way` equal to the addressed set's pointer. With no accepted allocate, `victim_valid` is low.
- R3: A returned victim way is never below the addressed set's lock count, so it is never a locked way.
- R4: After an allocate that returns the top way (NUM_WAYS-1), that set's pointer wraps to its current lock count. Otherwise the pointer steps up by one.
- R5: Command 2'b01 locks one more way in the addressed set. If the pointer would then point at a locked way, the pointer moves to the new lowest unlocked way.
- R6: Command 2'b01 on a set that already has MAX_LOCK locked ways is rejected. The set's state does not change, and `lock_err` is high for one cycle on the following cycle.
- R7: Command 2'b10 clears the addressed set's lock count to zero and leaves its pointer where it was. Later wraps then return to way 0.
- R8: State is kept per set. A set's pointer moves only on an allocate, or on a lock, addressed to that set.
- R9: When an allocate arrives together with command 2'b01 or 2'b10, the command is carried out and the allocate is dropped. No victim is returned and the pointer does not advance.
- R10: Command 2'b11 behaves exactly like 2'b00 (no command). An allocate presented with it is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_idx | input | 5 | Set addressed by this cycle's request |
| alloc_req | input | 1 | Request a victim in the addressed set |
| lock_cmd | input | 2 | 00 none, 01 lock one more way, 10 unlock all, 11 none |
| victim_valid | output | 1 | Victim returned this cycle |
| victim_way | output | 5 | Way chosen for replacement |
| lock_err | output | 1 | Previous lock command was rejected |

## Verification
The bench builds the block with its default values: 32 sets, 32 ways, and a lock limit of 28. With only 32 ways, a full rotation through an unlocked region takes at most 32 allocates, and filling a set to the limit takes 28 commands, so both fit in short directed sequences. Concentrating most random traffic on four sets lets lock counts reach the limit and hit the rejection path. The same traffic also sends pointers across the wrap boundary many times, under every lock count in between.

// File: rtl/vsel_pkg.sv
package vsel_pkg;

    parameter int unsigned VS_SETS     = 32;
    parameter int unsigned VS_WAYS     = 32;
    parameter int unsigned VS_MAX_LOCK = 28;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'b00,
        CMD_LOCK   = 2'b01,
        CMD_UNLOCK = 2'b10,
        CMD_RSVD   = 2'b11
    } lock_cmd_e;

    // A command that changes lock state pre-empts an allocate.
    function automatic logic cmd_blocks_alloc(lock_cmd_e c);
        return (c == CMD_LOCK) || (c == CMD_UNLOCK);
    endfunction

endpackage

// File: rtl/vsel_set_entry.sv
module vsel_set_entry
    import vsel_pkg::*;
#(
    parameter int unsigned NUM_WAYS = VS_WAYS,
    parameter int unsigned MAX_LOCK = VS_MAX_LOCK,
    parameter int unsigned WAY_W    = $clog2(NUM_WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel,
    input  logic             alloc,
    input  lock_cmd_e        cmd,
    output logic [WAY_W-1:0] cnt,
    output logic [WAY_W-1:0] ptr
);

    localparam logic [WAY_W-1:0] LIMIT = WAY_W'(MAX_LOCK);
    localparam logic [WAY_W-1:0] TOP   = WAY_W'(NUM_WAYS - 1);

    logic [WAY_W-1:0] cnt_q, ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ptr_q <= '0;
        end else if (sel) begin
            unique case (cmd)
                CMD_LOCK: begin
                    if (cnt_q < LIMIT) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (ptr_q <= cnt_q)
                            ptr_q <= cnt_q + 1'b1;
                    end
                end
                CMD_UNLOCK: begin
                    cnt_q <= '0;
                end
                default: begin
                    if (alloc)
                        ptr_q <= (ptr_q == TOP) ? cnt_q : ptr_q + 1'b1;
                end
            endcase
        end
    end

    assign cnt = cnt_q;
    assign ptr = ptr_q;

endmodule

// File: rtl/vsel_read_mux.sv
module vsel_read_mux #(
    parameter int unsigned NUM_SETS = 32,
    parameter int unsigned WAY_W    = 5,
    parameter int unsigned SET_W    = $clog2(NUM_SETS)
) (
    input  logic [SET_W-1:0] idx,
    input  logic [WAY_W-1:0] cnt_arr [NUM_SETS],
    input  logic [WAY_W-1:0] ptr_arr [NUM_SETS],
    output logic [WAY_W-1:0] rd_cnt,
    output logic [WAY_W-1:0] rd_ptr
);

    always_comb begin
        rd_cnt = cnt_arr[idx];
        rd_ptr = ptr_arr[idx];
    end

endmodule

// File: rtl/victim_sel.sv
module victim_sel
    import vsel_pkg::*;
#(
    parameter int unsigned NUM_SETS = VS_SETS,
    parameter int unsigned NUM_WAYS = VS_WAYS,
    parameter int unsigned MAX_LOCK = VS_MAX_LOCK,
    parameter int unsigned SET_W    = $clog2(NUM_SETS),
    parameter int unsigned WAY_W    = $clog2(NUM_WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] set_idx,
    input  logic             alloc_req,
    input  logic [1:0]       lock_cmd,
    output logic             victim_valid,
    output logic [WAY_W-1:0] victim_way,
    output logic             lock_err
);

    localparam logic [WAY_W-1:0] LIMIT = WAY_W'(MAX_LOCK);

    lock_cmd_e        cmd;
    logic             alloc_ok;
    logic [WAY_W-1:0] cnt_arr [NUM_SETS];
    logic [WAY_W-1:0] ptr_arr [NUM_SETS];
    logic [WAY_W-1:0] rd_cnt, rd_ptr;

    assign cmd      = lock_cmd_e'(lock_cmd);
    assign alloc_ok = alloc_req && !cmd_blocks_alloc(cmd);

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        vsel_set_entry #(
            .NUM_WAYS (NUM_WAYS),
            .MAX_LOCK (MAX_LOCK),
            .WAY_W    (WAY_W)
        ) u_entry (
            .clk   (clk),
            .rst   (rst),
            .sel   (set_idx == SET_W'(s)),
            .alloc (alloc_ok),
            .cmd   (cmd),
            .cnt   (cnt_arr[s]),
            .ptr   (ptr_arr[s])
        );
    end

    vsel_read_mux #(
        .NUM_SETS (NUM_SETS),
        .WAY_W    (WAY_W),
        .SET_W    (SET_W)
    ) u_rd (
        .idx     (set_idx),
        .cnt_arr (cnt_arr),
        .ptr_arr (ptr_arr),
        .rd_cnt  (rd_cnt),
        .rd_ptr  (rd_ptr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            victim_valid <= 1'b0;
            victim_way   <= '0;
            lock_err     <= 1'b0;
        end else begin
            victim_valid <= alloc_ok;
            if (alloc_ok)
                victim_way <= rd_ptr;
            lock_err <= (cmd == CMD_LOCK) && (rd_cnt == LIMIT);
        end
    end

endmodule

// File: rtl/vsel_checker.sv
module vsel_checker
    import vsel_pkg::*;
#(
    parameter int unsigned NUM_WAYS = VS_WAYS,
    parameter int unsigned MAX_LOCK = VS_MAX_LOCK,
    parameter int unsigned SET_W    = 5,
    parameter int unsigned WAY_W    = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [SET_W-1:0] set_idx,
    input logic             alloc_req,
    input logic [1:0]       lock_cmd,
    input logic [WAY_W-1:0] rd_cnt,
    input logic [WAY_W-1:0] rd_ptr,
    input logic             victim_valid,
    input logic [WAY_W-1:0] victim_way,
    input logic             lock_err
);

    localparam logic [WAY_W-1:0] LIMIT = WAY_W'(MAX_LOCK);
    localparam logic [WAY_W-1:0] TOP   = WAY_W'(NUM_WAYS - 1);

    logic busy_cmd;
    assign busy_cmd = (lock_cmd == CMD_LOCK) || (lock_cmd == CMD_UNLOCK);

    assert_victim_unlocked_R3: assert property (@(posedge clk) disable iff (rst)
        victim_valid |-> victim_way >= $past(rd_cnt));

    assert_wrap_to_floor_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(alloc_req && !busy_cmd) && $past(rd_ptr) == TOP && $stable(set_idx))
        |-> rd_ptr == $past(rd_cnt));

    assert_lock_grows_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(lock_cmd == CMD_LOCK) && $past(rd_cnt) < LIMIT && $stable(set_idx))
        |-> (rd_cnt == $past(rd_cnt) + 1'b1) && (rd_ptr >= rd_cnt) && !lock_err);

    assert_lock_reject_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(lock_cmd == CMD_LOCK) && $past(rd_cnt) == LIMIT && $stable(set_idx))
        |-> lock_err && rd_cnt == LIMIT && $stable(rd_ptr));

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
        rd_cnt <= LIMIT);

    assert_unlock_keeps_ptr_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(lock_cmd == CMD_UNLOCK) && $stable(set_idx))
        |-> rd_cnt == '0 && $stable(rd_ptr));

    assert_cmd_wins_R9: assert property (@(posedge clk) disable iff (rst)
        $past(alloc_req && busy_cmd) |-> !victim_valid);

endmodule

bind victim_sel vsel_checker #(
    .NUM_WAYS (NUM_WAYS),
    .MAX_LOCK (MAX_LOCK),
    .SET_W    (SET_W),
    .WAY_W    (WAY_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .set_idx      (set_idx),
    .alloc_req    (alloc_req),
    .lock_cmd     (lock_cmd),
    .rd_cnt       (rd_cnt),
    .rd_ptr       (rd_ptr),
    .victim_valid (victim_valid),
    .victim_way   (victim_way),
    .lock_err     (lock_err)
);

// File: tb/victim_sel_tb.sv
`timescale 1ns/1ps
module victim_sel_tb;

    localparam int SETS = 32;
    localparam int WAYS = 32;
    localparam int LIM  = 28;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] set_idx = '0;
    logic       alloc_req = 1'b0;
    logic [1:0] lock_cmd = 2'b00;
    logic       victim_valid;
    logic [4:0] victim_way;
    logic       lock_err;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    int m_cnt [SETS];
    int m_ptr [SETS];

    always #10 clk = ~clk;

    victim_sel u_dut (
        .clk          (clk),
        .rst          (rst),
        .set_idx      (set_idx),
        .alloc_req    (alloc_req),
        .lock_cmd     (lock_cmd),
        .victim_valid (victim_valid),
        .victim_way   (victim_way),
        .lock_err     (lock_err)
    );

    task automatic check(input int act, input int exp, input string tag, input string what);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Drive one request at a negedge, update the model, check at the next negedge.
    task automatic run_op(input int s, input bit a, input bit [1:0] c, input string tag_in);
        bit    exp_valid;
        int    exp_way;
        bit    exp_err;
        string tag;
        set_idx   = 5'(s);
        alloc_req = a;
        lock_cmd  = c;
        exp_valid = a && !(c == 2'b01 || c == 2'b10);
        exp_way   = m_ptr[s];
        exp_err   = (c == 2'b01) && (m_cnt[s] == LIM);
        if (c == 2'b01) tag = exp_err ? "R6" : "R5";
        else if (c == 2'b10) tag = "R7";
        else if (exp_valid) tag = (m_ptr[s] == WAYS - 1) ? "R4" : "R3";
        else tag = "R2";
        if (a && (c == 2'b01 || c == 2'b10)) tag = "R9";
        if (c == 2'b11) tag = "R10";
        if (tag_in != "") tag = tag_in;
        if (c == 2'b01) begin
            if (m_cnt[s] < LIM) begin
                m_cnt[s]++;
                if (m_ptr[s] < m_cnt[s]) m_ptr[s] = m_cnt[s];
            end
        end else if (c == 2'b10) begin
            m_cnt[s] = 0;
        end else if (a) begin
            m_ptr[s] = (m_ptr[s] == WAYS - 1) ? m_cnt[s] : m_ptr[s] + 1;
        end
        @(negedge clk);
        check(int'(victim_valid), int'(exp_valid), tag, "victim_valid");
        if (exp_valid) begin
            check(int'(victim_way), exp_way, tag, "victim_way");
            check(int'(victim_way >= 5'(m_cnt[s]) || m_cnt[s] == 0), 1, "R3", "not locked");
        end
        check(int'(lock_err), int'(exp_err), tag, "lock_err");
    endtask

    task automatic idle(input string tag);
        alloc_req = 1'b0;
        lock_cmd  = 2'b00;
        @(negedge clk);
        check(int'(victim_valid), 0, tag, "idle victim_valid");
        check(int'(lock_err), 0, tag, "idle lock_err");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < SETS; i++) begin
            m_cnt[i] = 0;
            m_ptr[i] = 0;
        end
        void'($urandom(32'd24680));
        repeat (3) @(negedge clk);
        check(int'(victim_valid), 0, "R1", "reset victim_valid");
        check(int'(lock_err), 0, "R1", "reset lock_err");
        rst = 1'b0;
        @(negedge clk);
        check(int'(victim_valid), 0, "R1", "post-reset victim_valid");

        // R1/R2: fresh set starts at way 0 and steps upward
        run_op(3, 1'b1, 2'b00, "R1");
        run_op(3, 1'b1, 2'b00, "R2");
        run_op(3, 1'b1, 2'b00, "R2");
        idle("R2");
        // R8: another set untouched by set 3 traffic
        run_op(7, 1'b1, 2'b00, "R8");
        run_op(3, 1'b1, 2'b00, "R8");
        // R5: pointer pushed up by locks
        for (int i = 0; i < 5; i++) run_op(9, 1'b0, 2'b01, "R5");
        run_op(9, 1'b1, 2'b00, "R5");
        // R6/R4: fill set 12 to the limit, reject one more, wrap to floor
        for (int i = 0; i < LIM; i++) run_op(12, 1'b0, 2'b01, "");
        run_op(12, 1'b0, 2'b01, "R6");
        idle("R6");
        for (int i = 0; i < 5; i++) run_op(12, 1'b1, 2'b00, "R4");
        // R7: unlock keeps pointer, later wrap reaches way 0
        run_op(12, 1'b0, 2'b10, "R7");
        for (int i = 0; i < 4; i++) run_op(12, 1'b1, 2'b00, "R7");
        // R9: command wins over allocate
        run_op(20, 1'b1, 2'b01, "R9");
        run_op(20, 1'b1, 2'b00, "R9");
        run_op(20, 1'b1, 2'b10, "R9");
        run_op(20, 1'b1, 2'b00, "R9");
        // R10: reserved code acts as no command
        run_op(21, 1'b1, 2'b11, "R10");
        run_op(21, 1'b0, 2'b11, "R10");
        run_op(21, 1'b1, 2'b00, "R10");

        // Constrained random traffic, mostly on four sets
        for (int n = 0; n < 4000; n++) begin
            int  s;
            int  r;
            bit  a;
            bit [1:0] c;
            s = ($urandom % 5 == 0) ? int'($urandom % SETS) : int'($urandom % 4);
            a = $urandom % 2;
            r = $urandom % 100;
            if (r < 60) c = 2'b00;
            else if (r < 88) c = 2'b01;
            else if (r < 92) c = 2'b10;
            else c = 2'b11;
            run_op(s, a, c, "");
        end
        idle("R2");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule